// File: doc/BRIEF.md
# Single-Bus Register-Transfer Datapath

This block is the storage and transfer fabric of a simple processor. One shared internal bus links a set of registers: a program counter, general registers, a scratch register, an address register that faces memory, a data register that sits between the internal bus and the memory data lines, and an adder with its operand and result registers. Each register has a capture strobe and a drive strobe. The controller raises a small set of strobes each clock to move one value across the bus.

The data register has two paths, one on each side. It can take a value from the bus or from the memory read lines, and it can drive the bus or the memory write lines. The address register takes its value from the bus and drives only the memory address lines. A memory access can wait on a completion handshake. While the wait control is high and completion is low, the whole datapath freezes. An external sequencer produces the strobes. This block does no decoding.

Top module: `sbus_datapath`

## Requirements
- R1: A register whose capture strobe (`pc_ld`, `gpr_ld[i]`, `tmp_ld`, `y_ld`) is high takes the bus value at the next rising clock edge. Registers whose strobe is low keep their value.
- R2: A register whose drive strobe is high places its contents on the bus in the same cycle, seen on `bus_mon`. A register whose drive strobe is low adds nothing to the bus. With no drive strobe high, the bus reads zero.
- R3: `drv_conflict` is high in any cycle where two or more drive strobes are high. It is low when at most one is high.
- R4: `mdr_ld_bus` loads the data register from the bus, and `mdr_drv` puts the data register on the bus.
- R5: While `mem_rd` is high, the data register loads `mem_rdata` in the cycle `mfc` is high. While `mfc` is low it keeps its value. A memory load takes priority over `mdr_ld_bus` in the same cycle.
- R6: While `mem_wr` is high, `mem_wdata` shows the data register and `mem_wr_req` is high. While `mem_wr` is low, `mem_wdata` is zero. `mem_rd_req` follows `mem_rd`.
- R7: `mar_ld` loads the address register from the low AW bits of the bus. `mem_addr` always shows the address register. The address register has no path onto the bus.
- R8: When `wait_mfc` is high and `mfc` is low, `stalled` is high and no register changes. When `mfc` is high, the strobes of that cycle take effect.
- R9: `z_ld` loads Z with Y plus the bus value. With `alu_inc` high it loads Y plus one instead. The sum wraps modulo 2^DW.
- R10: `ofs_drv` places the `ofs_field` input on the bus.
- R11: After reset, every register holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pc_ld | input | 1 | Program counter capture strobe |
| pc_drv | input | 1 | Program counter drive strobe |
| gpr_ld | input | NGPR | General register capture strobes |
| gpr_drv | input | NGPR | General register drive strobes |
| tmp_ld | input | 1 | Scratch register capture strobe |
| tmp_drv | input | 1 | Scratch register drive strobe |
| ofs_drv | input | 1 | Drive the offset field onto the bus |
| ofs_field | input | DW | Offset value from the instruction |
| y_ld | input | 1 | Adder operand register capture strobe |
| z_ld | input | 1 | Adder result register capture strobe |
| z_drv | input | 1 | Result register drive strobe |
| alu_inc | input | 1 | Add one instead of the bus value |
| mar_ld | input | 1 | Address register capture strobe |
| mdr_ld_bus | input | 1 | Data register capture from the bus |
| mdr_drv | input | 1 | Data register drive onto the bus |
| mem_rd | input | 1 | Memory read request control |
| mem_wr | input | 1 | Memory write request control |
| wait_mfc | input | 1 | Hold until memory completion |
| mfc | input | 1 | Memory function completed |
| mem_rdata | input | DW | Memory read data lines |
| mem_addr | output | AW | Memory address lines |
| mem_wdata | output | DW | Memory write data lines |
| mem_rd_req | output | 1 | Read request to memory |
| mem_wr_req | output | 1 | Write request to memory |
| bus_mon | output | DW | Internal bus value |
| drv_conflict | output | 1 | More than one bus driver active |
| stalled | output | 1 | Datapath frozen waiting for completion |

## Verification
The checker watches several properties on every cycle. An idle bus reads zero, and an empty or single-driver set never raises the conflict flag. The write lines stay quiet outside writes. A stall cycle leaves the address, data and result registers unchanged. The address register captures the bus. The data register takes read data on completion and holds it while completion is missing. Only the bench's scenarios show end-to-end transfer results: register-to-register copies, priority of a memory load over a bus load, Y-plus-bus and increment sums with wraparound, and a release from a stall that carries out the strobes of that cycle.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  // Bus source slots; general registers occupy the slots from SRC_GPR0 up.
  localparam int SRC_PC   = 0;
  localparam int SRC_MDR  = 1;
  localparam int SRC_Z    = 2;
  localparam int SRC_OFS  = 3;
  localparam int SRC_TMP  = 4;
  localparam int SRC_GPR0 = 5;

  typedef enum logic [1:0] {
    MDR_KEEP     = 2'd0,
    MDR_FROM_BUS = 2'd1,
    MDR_FROM_MEM = 2'd2
  } mdr_sel_e;
endpackage

// File: rtl/sbus_reg.sv
module sbus_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/sbus_bus_merge.sv
module sbus_bus_merge #(
  parameter int W = 16,
  parameter int N = 9
) (
  input  logic [N-1:0]        drv,
  input  logic [N-1:0][W-1:0] src,
  output logic [W-1:0]        bus,
  output logic                conflict
);
  logic [N-1:0][W-1:0] gated;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_gate
      assign gated[g] = drv[g] ? src[g] : '0;
    end
  endgenerate

  int unsigned n_active;

  always_comb begin
    bus      = '0;
    n_active = 0;
    for (int i = 0; i < N; i++) begin
      bus      = bus | gated[i];
      n_active = n_active + 32'(drv[i]);
    end
  end

  assign conflict = (n_active > 1);
endmodule

// File: rtl/sbus_adder.sv
module sbus_adder #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         y_ld,
  input  logic         z_ld,
  input  logic         inc,
  input  logic [W-1:0] bus,
  output logic [W-1:0] y_q,
  output logic [W-1:0] z_q
);
  function automatic logic [W-1:0] add_op(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic         one);
    logic [W-1:0] rhs;
    rhs = one ? W'(1) : b;
    return a + rhs;
  endfunction

  logic [W-1:0] sum;
  assign sum = add_op(y_q, bus, inc);

  sbus_reg #(.W(W)) u_y (.clk(clk), .rst_n(rst_n), .ld(y_ld), .d(bus), .q(y_q));
  sbus_reg #(.W(W)) u_z (.clk(clk), .rst_n(rst_n), .ld(z_ld), .d(sum), .q(z_q));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int DW   = 16,
  parameter int AW   = 12,
  parameter int NGPR = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pc_ld,
  input  logic            pc_drv,
  input  logic [NGPR-1:0] gpr_ld,
  input  logic [NGPR-1:0] gpr_drv,
  input  logic            tmp_ld,
  input  logic            tmp_drv,
  input  logic            ofs_drv,
  input  logic [DW-1:0]   ofs_field,
  input  logic            y_ld,
  input  logic            z_ld,
  input  logic            z_drv,
  input  logic            alu_inc,
  input  logic            mar_ld,
  input  logic            mdr_ld_bus,
  input  logic            mdr_drv,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic            wait_mfc,
  input  logic            mfc,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            mem_rd_req,
  output logic            mem_wr_req,
  output logic [DW-1:0]   bus_mon,
  output logic            drv_conflict,
  output logic            stalled
);
  import sbus_pkg::*;

  localparam int NSRC = SRC_GPR0 + NGPR;

  // Named internal events
  logic                       go;
  logic [DW-1:0]              bus;
  logic [NSRC-1:0]            drv_vec;
  logic [NSRC-1:0][DW-1:0]    src_vec;
  logic [DW-1:0]              pc_q, tmp_q, y_q, z_q, mdr_q;
  logic [AW-1:0]              mar_q;
  logic [NGPR-1:0][DW-1:0]    gpr_q;
  mdr_sel_e                   mdr_sel;

  assign stalled = wait_mfc & ~mfc;
  assign go      = ~stalled;

  // Bus sources
  always_comb begin
    drv_vec = '0;
    src_vec = '0;
    drv_vec[SRC_PC]  = pc_drv;  src_vec[SRC_PC]  = pc_q;
    drv_vec[SRC_MDR] = mdr_drv; src_vec[SRC_MDR] = mdr_q;
    drv_vec[SRC_Z]   = z_drv;   src_vec[SRC_Z]   = z_q;
    drv_vec[SRC_OFS] = ofs_drv; src_vec[SRC_OFS] = ofs_field;
    drv_vec[SRC_TMP] = tmp_drv; src_vec[SRC_TMP] = tmp_q;
    for (int i = 0; i < NGPR; i++) begin
      drv_vec[SRC_GPR0+i] = gpr_drv[i];
      src_vec[SRC_GPR0+i] = gpr_q[i];
    end
  end

  sbus_bus_merge #(.W(DW), .N(NSRC)) u_merge (
    .drv(drv_vec), .src(src_vec), .bus(bus), .conflict(drv_conflict)
  );

  // Plain bus registers
  sbus_reg #(.W(DW)) u_pc  (.clk(clk), .rst_n(rst_n), .ld(pc_ld  & go), .d(bus), .q(pc_q));
  sbus_reg #(.W(DW)) u_tmp (.clk(clk), .rst_n(rst_n), .ld(tmp_ld & go), .d(bus), .q(tmp_q));
  sbus_reg #(.W(AW)) u_mar (.clk(clk), .rst_n(rst_n), .ld(mar_ld & go), .d(bus[AW-1:0]), .q(mar_q));

  genvar g;
  generate
    for (g = 0; g < NGPR; g++) begin : g_gpr
      sbus_reg #(.W(DW)) u_r (
        .clk(clk), .rst_n(rst_n), .ld(gpr_ld[g] & go), .d(bus), .q(gpr_q[g])
      );
    end
  endgenerate

  sbus_adder #(.W(DW)) u_add (
    .clk(clk), .rst_n(rst_n), .y_ld(y_ld & go), .z_ld(z_ld & go),
    .inc(alu_inc), .bus(bus), .y_q(y_q), .z_q(z_q)
  );

  // Data register with two input paths; memory side wins
  always_comb begin
    if (mem_rd && mfc)            mdr_sel = MDR_FROM_MEM;
    else if (mdr_ld_bus && go)    mdr_sel = MDR_FROM_BUS;
    else                          mdr_sel = MDR_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mdr_q <= '0;
    else begin
      case (mdr_sel)
        MDR_FROM_MEM: mdr_q <= mem_rdata;
        MDR_FROM_BUS: mdr_q <= bus;
        default:      mdr_q <= mdr_q;
      endcase
    end
  end

  // Memory side
  assign mem_addr   = mar_q;
  assign mem_wdata  = mem_wr ? mdr_q : '0;
  assign mem_rd_req = mem_rd;
  assign mem_wr_req = mem_wr;
  assign bus_mon    = bus;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int DW   = 16,
  parameter int AW   = 12,
  parameter int NSRC = 9
) (
  input logic            clk,
  input logic            rst_n,
  input logic            stalled,
  input logic            mfc,
  input logic            mem_rd,
  input logic            mem_wr,
  input logic            mdr_ld_bus,
  input logic            mar_ld,
  input logic [NSRC-1:0] drv_vec,
  input logic            drv_conflict,
  input logic [DW-1:0]   bus,
  input logic [DW-1:0]   mdr_q,
  input logic [AW-1:0]   mar_q,
  input logic [DW-1:0]   z_q,
  input logic [DW-1:0]   mem_rdata,
  input logic [DW-1:0]   mem_wdata
);
  // R2
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_vec == '0) |-> (bus == '0));

  // R3
  no_false_conflict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv_vec) |-> !drv_conflict);

  // R5
  rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && mfc) |=> (mdr_q == $past(mem_rdata)));

  // R5
  rd_wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !mfc && !mdr_ld_bus) |=> $stable(mdr_q));

  // R6
  wdata_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr |-> (mem_wdata == '0));

  // R7
  mar_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mar_ld && !stalled) |=> (mar_q == $past(bus[AW-1:0])));

  // R8
  stall_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stalled |=> ($stable(mar_q) && $stable(mdr_q) && $stable(z_q)));
endmodule

bind sbus_datapath sbus_datapath_chk #(.DW(DW), .AW(AW), .NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .stalled(stalled), .mfc(mfc), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mdr_ld_bus(mdr_ld_bus), .mar_ld(mar_ld), .drv_vec(drv_vec),
  .drv_conflict(drv_conflict), .bus(bus), .mdr_q(mdr_q), .mar_q(mar_q),
  .z_q(z_q), .mem_rdata(mem_rdata), .mem_wdata(mem_wdata)
);

// File: tb/test_sbus_datapath.sv
module test_sbus_datapath;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 12;
  localparam int NGPR = 4;

  logic clk = 0;
  logic rst_n = 0;
  logic pc_ld, pc_drv, tmp_ld, tmp_drv, ofs_drv, y_ld, z_ld, z_drv, alu_inc;
  logic mar_ld, mdr_ld_bus, mdr_drv, mem_rd, mem_wr, wait_mfc, mfc;
  logic [NGPR-1:0] gpr_ld, gpr_drv;
  logic [DW-1:0] ofs_field, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, bus_mon;
  logic mem_rd_req, mem_wr_req, drv_conflict, stalled;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbus_datapath #(.DW(DW), .AW(AW), .NGPR(NGPR)) i_sbus_datapath (.*);

  task automatic clr();
    pc_ld = 0; pc_drv = 0; tmp_ld = 0; tmp_drv = 0; ofs_drv = 0; y_ld = 0;
    z_ld = 0; z_drv = 0; alu_inc = 0; mar_ld = 0; mdr_ld_bus = 0; mdr_drv = 0;
    mem_rd = 0; mem_wr = 0; wait_mfc = 0; mfc = 0; gpr_ld = '0; gpr_drv = '0;
    ofs_field = '0; mem_rdata = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Source codes for peek(): 0 pc, 1 mdr, 2 z, 3 tmp, 4.. gpr
  task automatic peek(int s, output logic [DW-1:0] v);
    case (s)
      0: pc_drv = 1;
      1: mdr_drv = 1;
      2: z_drv = 1;
      3: tmp_drv = 1;
      default: gpr_drv[s-4] = 1;
    endcase
    #1 v = bus_mon;
    clr();
  endtask

  task automatic put_ofs(logic [DW-1:0] val);
    ofs_field = val; ofs_drv = 1;
  endtask

  task automatic t_reset();
    logic [DW-1:0] v;
    for (int s = 0; s < 4 + NGPR; s++) begin
      peek(s, v); chk("R11 reset register", v, '0);
    end
    chk("R11 reset mem_addr", DW'(mem_addr), '0);
  endtask

  task automatic t_transfer();
    logic [DW-1:0] v;
    put_ofs(16'h1234); gpr_ld[0] = 1; #1;
    chk("R10 offset on bus", bus_mon, 16'h1234);
    tick(); clr();
    gpr_drv[0] = 1; gpr_ld[2] = 1; tick(); clr();
    peek(6, v); chk("R1 R0 to R2 copy", v, 16'h1234);
    peek(4, v); chk("R1 R0 kept", v, 16'h1234);
    peek(5, v); chk("R1 R1 untouched", v, 16'h0000);
    gpr_drv[2] = 1; pc_ld = 1; tmp_ld = 1; tick(); clr();
    peek(0, v); chk("R1 pc load", v, 16'h1234);
    peek(3, v); chk("R2 tmp drive", v, 16'h1234);
  endtask

  task automatic t_conflict();
    #1 chk("R2 idle bus zero", bus_mon, '0);
    chk("R3 no conflict idle", DW'(drv_conflict), '0);
    pc_drv = 1; #1 chk("R3 single driver", DW'(drv_conflict), '0);
    gpr_drv[1] = 1; #1 chk("R3 two drivers", DW'(drv_conflict), 1);
    clr();
  endtask

  task automatic t_mdr_bus();
    logic [DW-1:0] v;
    put_ofs(16'hBEEF); mdr_ld_bus = 1; tick(); clr();
    peek(1, v); chk("R4 mdr bus round trip", v, 16'hBEEF);
    #1 chk("R6 wdata quiet", mem_wdata, '0);
    mem_wr = 1; #1;
    chk("R6 wdata from mdr", mem_wdata, 16'hBEEF);
    chk("R6 write request", DW'(mem_wr_req), 1);
    clr();
  endtask

  task automatic t_mar();
    put_ofs(16'hFABC); mar_ld = 1; tick(); clr();
    chk("R7 mar drives address", DW'(mem_addr), 16'h0ABC);
    #1 chk("R7 mar not on bus", bus_mon, '0);
  endtask

  task automatic t_mem_read();
    logic [DW-1:0] v;
    mem_rd = 1; wait_mfc = 1; mfc = 0; mem_rdata = 16'h5A5A;
    for (int k = 0; k < 3; k++) tick();
    chk("R8 stalled while waiting", DW'(stalled), 1);
    chk("R6 read request", DW'(mem_rd_req), 1);
    mdr_drv = 1; #1 chk("R5 mdr held before mfc", bus_mon, 16'hBEEF);
    mdr_drv = 0; mfc = 1; #1;
    chk("R8 stall released", DW'(stalled), 0);
    tick(); clr();
    peek(1, v); chk("R5 mdr loaded on mfc", v, 16'h5A5A);
    mem_rd = 1; mfc = 1; mem_rdata = 16'h7777; put_ofs(16'h1111); mdr_ld_bus = 1;
    tick(); clr();
    peek(1, v); chk("R5 memory beats bus", v, 16'h7777);
  endtask

  task automatic t_stall();
    logic [DW-1:0] v;
    wait_mfc = 1; mfc = 0; put_ofs(16'h0F0F);
    gpr_ld[3] = 1; pc_ld = 1; mar_ld = 1; y_ld = 1; tmp_ld = 1;
    tick(); clr();
    peek(7, v); chk("R8 R3 frozen", v, 16'h0000);
    peek(0, v); chk("R8 pc frozen", v, 16'h1234);
    chk("R8 mar frozen", DW'(mem_addr), 16'h0ABC);
    wait_mfc = 1; mfc = 1; put_ofs(16'h0F0F); gpr_ld[3] = 1; mar_ld = 1;
    tick(); clr();
    peek(7, v); chk("R8 load on release", v, 16'h0F0F);
    chk("R8 mar on release", DW'(mem_addr), 16'h0F0F);
  endtask

  task automatic t_adder();
    logic [DW-1:0] v;
    put_ofs(16'h0010); y_ld = 1; tick(); clr();
    put_ofs(16'h0005); z_ld = 1; tick(); clr();
    peek(2, v); chk("R9 y plus bus", v, 16'h0015);
    put_ofs(16'h9999); z_ld = 1; alu_inc = 1; tick(); clr();
    peek(2, v); chk("R9 increment", v, 16'h0011);
    put_ofs(16'hFFFF); y_ld = 1; tick(); clr();
    put_ofs(16'h0002); z_ld = 1; tick(); clr();
    peek(2, v); chk("R9 wraparound", v, DW'((32'hFFFF + 32'h2) & 32'hFFFF));
  endtask

  initial begin
    clr();
    #(CLK_PERIOD*3) rst_n = 1;
    tick();
    t_reset();
    t_transfer();
    t_conflict();
    t_mdr_bus();
    t_mar();
    t_mem_read();
    t_stall();
    t_adder();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule